// File: doc/BRIEF.md
# Two-Level I/O Device-Select Controller

This block extends a small I/O command field into an addressed space of 256 input and 256 output devices. The processor first writes a device address into an 8-bit select register. Later commands then act on whichever device that register names: they send a control byte, send a data byte, fetch a status byte or fetch an input byte. The block decodes the command field together with the transfer direction and the write strobe. It presents the latched device address to the peripherals, together with a separate one-cycle strobe for each kind of transfer.

Output-side commands act only when the write strobe is seen with the direction line low. Input-side commands act whenever the direction line is high, and the strobe plays no part in them. For an input command the controller captures the byte that the selected device presents, drives it back toward the processor bus and raises the bus enable. Every output is registered, so each response appears one clock after the edge that samples the command.

Top module: `io2l_ctrl`

## Requirements
- R1: While `rst` is high at a rising edge, the next cycle shows `dev_addr`, `dout_data` and `bus_out` at 0 and `ctl_stb`, `dout_stb`, `stat_rd`, `din_rd` and `bus_oe` low.
- R2: Command code 1 with `in_cycle` low and `wr_stb` high loads `bus_in` into the select register, and `dev_addr` shows the new value in the next cycle.
- R3: In every other cycle `dev_addr` keeps its previous value. This includes code 1 without the strobe and code 1 with `in_cycle` high.
- R4: Code 2 with `in_cycle` low and `wr_stb` high raises `ctl_stb` for exactly the next cycle, with `dout_data` equal to the bus byte.
- R5: Code 3 with `in_cycle` low and `wr_stb` high raises `dout_stb` for exactly the next cycle, with `dout_data` equal to the bus byte.
- R6: Codes 2 and 3 with `in_cycle` low and `wr_stb` low produce no strobe, and `dout_data` keeps its value.
- R7: Code 2 with `in_cycle` high raises `stat_rd` and `bus_oe` in the next cycle, with `bus_out` equal to the `dev_in` byte sampled at that edge. The value of `wr_stb` does not matter.
- R8: Code 3 with `in_cycle` high raises `din_rd` and `bus_oe` in the next cycle, with `bus_out` equal to the sampled `dev_in`.
- R9: Codes 0, 4, 5, 6 and 7 produce no strobe and no bus enable in either direction, leave `dev_addr` and `dout_data` unchanged, and give `bus_out` = 0.
- R10: At most one of `ctl_stb`, `dout_stb`, `stat_rd` and `din_rd` is high in any cycle. `bus_oe` is high exactly when an input strobe is high, and `bus_out` is 0 whenever `bus_oe` is low.
- R11: All 256 device addresses can be loaded and read back unchanged on `dev_addr`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| io_cmd | input | 3 | I/O command code, where 0 means no I/O |
| in_cycle | input | 1 | High for an input transfer, low for an output transfer |
| wr_stb | input | 1 | Write strobe that qualifies output commands |
| bus_in | input | 8 | Byte on the processor bus during an output |
| dev_in | input | 8 | Byte presented by the selected input device |
| dev_addr | output | 8 | Currently selected device address |
| ctl_stb | output | 1 | Control-byte strobe to the selected output device |
| dout_stb | output | 1 | Data-byte strobe to the selected output device |
| dout_data | output | 8 | Byte that goes with `ctl_stb` or `dout_stb` |
| stat_rd | output | 1 | Status-read strobe to the selected input device |
| din_rd | output | 1 | Data-read strobe to the selected input device |
| bus_oe | output | 1 | Enables `bus_out` onto the processor bus |
| bus_out | output | 8 | Captured input byte |

## Verification
The assertions check on every cycle the one-cycle response to each live command: address loading and holding, control and data strobes with their byte, and input strobes with the captured byte. They also check that the strobes exclude one another and that the bus enable matches the input strobes. Only the bench's scenarios can show some of the other behaviour. This covers the full sweep of 256 addresses. It also covers the combinations of unused codes, direction and strobe, where the bench confirms that `dout_data` and `dev_addr` stay untouched across long sequences, and the recovery from a reset that arrives in the middle of a sequence.

// File: rtl/io2l_pkg.sv
package io2l_pkg;
  typedef enum logic [2:0] {
    K_NONE = 3'd0,
    K_SEL  = 3'd1,
    K_CTL  = 3'd2,
    K_DOUT = 3'd3,
    K_STAT = 3'd4,
    K_DIN  = 3'd5
  } io_kind_e;
endpackage

// File: rtl/io2l_decode.sv
module io2l_decode
  import io2l_pkg::*;
#(
  parameter int CMD_W     = 3,
  parameter int SEL_CODE  = 1,
  parameter int CTL_CODE  = 2,
  parameter int DOUT_CODE = 3,
  parameter int STAT_CODE = 2,
  parameter int DIN_CODE  = 3
) (
  input  logic [CMD_W-1:0] io_cmd,
  input  logic             in_cycle,
  input  logic             wr_stb,
  output io_kind_e         kind
);
  always_comb begin
    kind = K_NONE;
    if (in_cycle) begin
      // input side: enabled for the whole cycle, strobe not needed
      if (io_cmd == CMD_W'(STAT_CODE))     kind = K_STAT;
      else if (io_cmd == CMD_W'(DIN_CODE)) kind = K_DIN;
    end else if (wr_stb) begin
      if (io_cmd == CMD_W'(SEL_CODE))       kind = K_SEL;
      else if (io_cmd == CMD_W'(CTL_CODE))  kind = K_CTL;
      else if (io_cmd == CMD_W'(DOUT_CODE)) kind = K_DOUT;
    end
  end
endmodule

// File: rtl/io2l_sel_reg.sv
module io2l_sel_reg
  import io2l_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  io_kind_e          kind,
  input  logic [DATA_W-1:0] bus_in,
  output logic [DATA_W-1:0] sel_q
);
  always_ff @(posedge clk) begin
    if (rst)               sel_q <= '0;
    else if (kind == K_SEL) sel_q <= bus_in;
  end
endmodule

// File: rtl/io2l_out_stage.sv
module io2l_out_stage
  import io2l_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  io_kind_e          kind,
  input  logic [DATA_W-1:0] bus_in,
  output logic              ctl_stb,
  output logic              dout_stb,
  output logic [DATA_W-1:0] dout_data
);
  always_ff @(posedge clk) begin
    if (rst) begin
      ctl_stb   <= 1'b0;
      dout_stb  <= 1'b0;
      dout_data <= '0;
    end else begin
      ctl_stb  <= (kind == K_CTL);
      dout_stb <= (kind == K_DOUT);
      if (kind == K_CTL || kind == K_DOUT) dout_data <= bus_in;
    end
  end
endmodule

// File: rtl/io2l_in_stage.sv
module io2l_in_stage
  import io2l_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  io_kind_e          kind,
  input  logic [DATA_W-1:0] dev_in,
  output logic              stat_rd,
  output logic              din_rd,
  output logic              bus_oe,
  output logic [DATA_W-1:0] bus_out
);
  logic rd_any;
  assign rd_any = (kind == K_STAT) || (kind == K_DIN);

  always_ff @(posedge clk) begin
    if (rst) begin
      stat_rd <= 1'b0;
      din_rd  <= 1'b0;
      bus_oe  <= 1'b0;
      bus_out <= '0;
    end else begin
      stat_rd <= (kind == K_STAT);
      din_rd  <= (kind == K_DIN);
      bus_oe  <= rd_any;
      bus_out <= rd_any ? dev_in : '0;
    end
  end
endmodule

// File: rtl/io2l_ctrl.sv
module io2l_ctrl
  import io2l_pkg::*;
#(
  parameter int DATA_W    = 8,
  parameter int CMD_W     = 3,
  parameter int SEL_CODE  = 1,
  parameter int CTL_CODE  = 2,
  parameter int DOUT_CODE = 3,
  parameter int STAT_CODE = 2,
  parameter int DIN_CODE  = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [CMD_W-1:0]  io_cmd,
  input  logic              in_cycle,
  input  logic              wr_stb,
  input  logic [DATA_W-1:0] bus_in,
  input  logic [DATA_W-1:0] dev_in,
  output logic [DATA_W-1:0] dev_addr,
  output logic              ctl_stb,
  output logic              dout_stb,
  output logic [DATA_W-1:0] dout_data,
  output logic              stat_rd,
  output logic              din_rd,
  output logic              bus_oe,
  output logic [DATA_W-1:0] bus_out
);
  io_kind_e kind;

  io2l_decode #(
    .CMD_W(CMD_W), .SEL_CODE(SEL_CODE), .CTL_CODE(CTL_CODE),
    .DOUT_CODE(DOUT_CODE), .STAT_CODE(STAT_CODE), .DIN_CODE(DIN_CODE)
  ) u_dec (
    .io_cmd(io_cmd), .in_cycle(in_cycle), .wr_stb(wr_stb), .kind(kind)
  );

  io2l_sel_reg #(.DATA_W(DATA_W)) u_sel (
    .clk(clk), .rst(rst), .kind(kind), .bus_in(bus_in), .sel_q(dev_addr)
  );

  io2l_out_stage #(.DATA_W(DATA_W)) u_out (
    .clk(clk), .rst(rst), .kind(kind), .bus_in(bus_in),
    .ctl_stb(ctl_stb), .dout_stb(dout_stb), .dout_data(dout_data)
  );

  io2l_in_stage #(.DATA_W(DATA_W)) u_in (
    .clk(clk), .rst(rst), .kind(kind), .dev_in(dev_in),
    .stat_rd(stat_rd), .din_rd(din_rd), .bus_oe(bus_oe), .bus_out(bus_out)
  );
endmodule

// File: rtl/io2l_ctrl_chk.sv
module io2l_ctrl_chk #(
  parameter int DATA_W    = 8,
  parameter int CMD_W     = 3,
  parameter int SEL_CODE  = 1,
  parameter int CTL_CODE  = 2,
  parameter int DOUT_CODE = 3,
  parameter int STAT_CODE = 2,
  parameter int DIN_CODE  = 3
) (
  input logic              clk,
  input logic              rst,
  input logic [CMD_W-1:0]  io_cmd,
  input logic              in_cycle,
  input logic              wr_stb,
  input logic [DATA_W-1:0] bus_in,
  input logic [DATA_W-1:0] dev_in,
  input logic [DATA_W-1:0] dev_addr,
  input logic              ctl_stb,
  input logic              dout_stb,
  input logic [DATA_W-1:0] dout_data,
  input logic              stat_rd,
  input logic              din_rd,
  input logic              bus_oe,
  input logic [DATA_W-1:0] bus_out
);
  logic ld_sel, wr_ctl, wr_dat, rd_st, rd_dt;
  assign ld_sel = !in_cycle && wr_stb && io_cmd == CMD_W'(SEL_CODE);
  assign wr_ctl = !in_cycle && wr_stb && io_cmd == CMD_W'(CTL_CODE);
  assign wr_dat = !in_cycle && wr_stb && io_cmd == CMD_W'(DOUT_CODE);
  assign rd_st  = in_cycle && io_cmd == CMD_W'(STAT_CODE);
  assign rd_dt  = in_cycle && io_cmd == CMD_W'(DIN_CODE);

  p_reset_r1: assert property (@(posedge clk)
    rst |=> (dev_addr == '0 && !ctl_stb && !dout_stb && !stat_rd && !din_rd && !bus_oe));

  p_sel_load_r2: assert property (@(posedge clk) disable iff (rst)
    ld_sel |=> dev_addr == $past(bus_in));

  p_sel_hold_r3: assert property (@(posedge clk) disable iff (rst)
    !ld_sel |=> $stable(dev_addr));

  p_ctl_r4: assert property (@(posedge clk) disable iff (rst)
    wr_ctl |=> (ctl_stb && dout_data == $past(bus_in)));

  p_dat_r5: assert property (@(posedge clk) disable iff (rst)
    wr_dat |=> (dout_stb && dout_data == $past(bus_in)));

  p_no_write_r6: assert property (@(posedge clk) disable iff (rst)
    !(wr_ctl || wr_dat) |=> (!ctl_stb && !dout_stb && $stable(dout_data)));

  p_stat_r7: assert property (@(posedge clk) disable iff (rst)
    rd_st |=> (stat_rd && bus_oe && bus_out == $past(dev_in)));

  p_din_r8: assert property (@(posedge clk) disable iff (rst)
    rd_dt |=> (din_rd && bus_oe && bus_out == $past(dev_in)));

  p_idle_r9: assert property (@(posedge clk) disable iff (rst)
    !(rd_st || rd_dt) |=> (!stat_rd && !din_rd && !bus_oe && bus_out == '0));

  p_excl_r10: assert property (@(posedge clk) disable iff (rst)
    $onehot0({ctl_stb, dout_stb, stat_rd, din_rd}));
endmodule

bind io2l_ctrl io2l_ctrl_chk #(
  .DATA_W(DATA_W), .CMD_W(CMD_W), .SEL_CODE(SEL_CODE), .CTL_CODE(CTL_CODE),
  .DOUT_CODE(DOUT_CODE), .STAT_CODE(STAT_CODE), .DIN_CODE(DIN_CODE)
) u_chk (
  .clk(clk), .rst(rst), .io_cmd(io_cmd), .in_cycle(in_cycle), .wr_stb(wr_stb),
  .bus_in(bus_in), .dev_in(dev_in), .dev_addr(dev_addr), .ctl_stb(ctl_stb),
  .dout_stb(dout_stb), .dout_data(dout_data), .stat_rd(stat_rd), .din_rd(din_rd),
  .bus_oe(bus_oe), .bus_out(bus_out)
);

// File: tb/test_io2l_ctrl.sv
module test_io2l_ctrl;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [2:0] io_cmd = '0;
  logic       in_cycle = 1'b0;
  logic       wr_stb = 1'b0;
  logic [7:0] bus_in = '0;
  logic [7:0] dev_in = '0;
  logic [7:0] dev_addr, dout_data, bus_out;
  logic       ctl_stb, dout_stb, stat_rd, din_rd, bus_oe;

  int checks = 0;
  int errors = 0;
  logic [7:0] m_addr = '0;
  logic [7:0] m_dout = '0;

  always #10 clk = ~clk;  // 50 MHz

  io2l_ctrl i_io2l_ctrl (
    .clk(clk), .rst(rst), .io_cmd(io_cmd), .in_cycle(in_cycle), .wr_stb(wr_stb),
    .bus_in(bus_in), .dev_in(dev_in), .dev_addr(dev_addr), .ctl_stb(ctl_stb),
    .dout_stb(dout_stb), .dout_data(dout_data), .stat_rd(stat_rd), .din_rd(din_rd),
    .bus_oe(bus_oe), .bus_out(bus_out)
  );

  function automatic logic [28:0] pack_out();
    return {dev_addr, ctl_stb, dout_stb, dout_data, stat_rd, din_rd, bus_oe, bus_out};
  endfunction

  task automatic compare(input string tag, input logic [28:0] exp);
    logic [28:0] act;
    act = pack_out();
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // Drive one command at a falling edge, let one rising edge pass, compare.
  task automatic step(input logic [2:0] c, input logic dir, input logic s,
                      input logic [7:0] b, input logic [7:0] d, input string tag);
    logic e_ctl, e_dst, e_st, e_dn;
    e_ctl = 0; e_dst = 0; e_st = 0; e_dn = 0;
    if (dir) begin
      if (c == 3'd2) e_st = 1;
      if (c == 3'd3) e_dn = 1;
    end else if (s) begin
      if (c == 3'd1) m_addr = b;
      if (c == 3'd2) begin e_ctl = 1; m_dout = b; end
      if (c == 3'd3) begin e_dst = 1; m_dout = b; end
    end
    io_cmd = c; in_cycle = dir; wr_stb = s; bus_in = b; dev_in = d;
    @(negedge clk);
    compare(tag, {m_addr, e_ctl, e_dst, m_dout, e_st, e_dn, e_st | e_dn,
                  (e_st | e_dn) ? d : 8'h00});
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=running expected=done");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    rst = 1'b1;
    bus_in = 8'hA5; dev_in = 8'h5A; io_cmd = 3'd1; wr_stb = 1'b1;
    repeat (3) @(negedge clk);
    compare("R1 reset", 29'd0);
    rst = 1'b0;
    step(3'd0, 0, 0, 8'h00, 8'h00, "R1 idle after reset");

    // R11 / R2 / R4 / R5 / R7 / R8: full address sweep with typed transfers
    for (int a = 0; a < 256; a++) begin
      step(3'd1, 0, 1, 8'(a), 8'h00, "R11 R2 load address");
      step(3'd2, 0, 1, 8'(~a), 8'h00, "R4 control byte");
      step(3'd3, 0, 1, 8'(a ^ 8'h3C), 8'h00, "R5 data byte");
      step(3'd2, 1, 0, 8'h00, 8'(a + 7), "R7 status read");
      step(3'd3, 1, 1, 8'h00, 8'(a * 3), "R8 data read");
    end

    // R3: select code without strobe or in input direction does not load
    step(3'd1, 0, 1, 8'h42, 8'h00, "R2 load 0x42");
    step(3'd1, 0, 0, 8'h99, 8'h00, "R3 no strobe");
    step(3'd1, 1, 1, 8'h77, 8'h11, "R3 input direction");

    // R6: output codes without strobe
    step(3'd2, 0, 0, 8'hEE, 8'h00, "R6 ctl without strobe");
    step(3'd3, 0, 0, 8'hDD, 8'h00, "R6 data without strobe");

    // R9: unused codes, every direction and strobe combination
    for (int c = 4; c < 9; c++) begin
      for (int m = 0; m < 4; m++) begin
        step(3'(c == 8 ? 0 : c), m[0], m[1], 8'(c * 17 + m), 8'(m * 33 + 1),
             "R9 unused code");
      end
    end

    // R10: back-to-back mixed kinds, one strobe per cycle
    step(3'd2, 0, 1, 8'h10, 8'h00, "R10 ctl");
    step(3'd2, 1, 1, 8'h00, 8'h20, "R10 stat after ctl");
    step(3'd3, 0, 1, 8'h30, 8'h00, "R10 data after stat");
    step(3'd3, 1, 0, 8'h00, 8'h40, "R10 din after data");
    step(3'd0, 1, 0, 8'h00, 8'h50, "R10 idle after din");

    // R1: reset in the middle of a sequence
    step(3'd1, 0, 1, 8'hC3, 8'h00, "R2 load before reset");
    rst = 1'b1;
    @(negedge clk);
    m_addr = '0; m_dout = '0;
    compare("R1 mid-run reset", 29'd0);
    rst = 1'b0;
    io_cmd = '0; wr_stb = 0; in_cycle = 0;
    step(3'd0, 0, 0, 8'h00, 8'h00, "R1 held after reset");

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule